// File: doc/BRIEF.md
# Vector Pattern Sequencer with Per-Pin Tristate and Response Capture

This block replays stored per-cycle test vectors onto a group of bidirectional pins and records what the pins carry back. Every vector has three parts. The first is a drive value for each pin. The second is a per-pin enable that either drives the pin or releases it to high impedance. The third is an optional strobe bit that pulses a trigger output for external equipment. Because each vector carries its own enables, one stored pattern can play a serial bus in which a pin changes direction partway through a transfer.

The host fills the drive memory and the enable/strobe memory through a valid/ready write port. It then programs a first and last vector address, a rate divider and a loop option, and pulses start. An address generator walks the range inclusively. It holds each vector for a programmable number of system clocks. In the final clock of each vector it stores the sampled pins into a record memory at that vector's own address. Once the run has ended, the host reads the record memory through a plain synchronous read port.

Each pin is split into a drive value, an enable and a sampled input. The pad ring joins these three signals into a real bidirectional pad.

The write port follows these back-pressure rules. A write takes effect only in a cycle where both `wr_valid` and `wr_ready` are high. `wr_ready` is low for the whole of a run, so the host must hold its data until the run ends. A writer that does not wait has its write dropped. The run configuration is captured at start, so it may change freely during a run.

Top module: `vseq_engine`

## Requirements
- R1: While reset is held, and right after it, `busy`, `done`, `trig`, `pin_oe`, `pin_out` and `rd_data` are all zero, and `wr_ready` is one.
- R2: A write is accepted in a cycle with `wr_valid` and `wr_ready` both high. With `wr_sel`=0, `wr_data[PINS-1:0]` is stored as the drive value at `wr_addr`. With `wr_sel`=1, `wr_data[PINS-1:0]` is stored as the pin enables and `wr_data[PINS]` as the strobe bit.
- R3: `wr_ready` is low while `busy` is high, and a write offered during a run leaves both memories unchanged.
- R4: A `start` pulse while idle captures `start_addr`, `end_addr`, `rate_div` and `loop_en`. From the next cycle `busy` is high and the pins present vector `start_addr`. A `start` while busy is ignored.
- R5: Each vector is presented for `rate_div`+1 clocks, so a divider of 0 gives one vector per clock. Addresses step by one modulo DEPTH, wrapping from DEPTH-1 to 0.
- R6: While busy, `pin_oe[i]` equals enable bit i of the current vector and `pin_out[i]` equals its drive bit i. While idle, both buses are all zero, so every pin is released.
- R7: `pin_in` sampled in the last clock of vector N is written to record address N. `rd_data` shows the record entry at `rd_addr` one clock after that address is presented.
- R8: After the end-address vector completes with looping off, `busy` falls and `done` rises. `done` stays high until the next accepted start.
- R9: With `loop_en` set, the vector after the end address is the start address again, and the run goes on until stopped.
- R10: `stop` raised in any busy cycle ends the run when the current vector completes. That vector is still captured, and `done` is then set.
- R11: `trig` is high exactly while busy and the current vector's strobe bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Write can be accepted (low during a run) |
| wr_sel | input | 1 | 0 = drive memory, 1 = enable/strobe memory |
| wr_addr | input | AW | Vector address for the write |
| wr_data | input | PINS+1 | Write data; bit PINS is the strobe when `wr_sel`=1 |
| start | input | 1 | Begin a run (ignored while busy) |
| stop | input | 1 | End the run after the current vector |
| loop_en | input | 1 | Wrap from end address back to start address |
| start_addr | input | AW | First vector of the run |
| end_addr | input | AW | Last vector of the run (inclusive) |
| rate_div | input | DIVW | Clocks per vector minus one |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has finished |
| rd_addr | input | AW | Record memory read address |
| rd_data | output | PINS | Record entry, one clock after `rd_addr` |
| pin_in | input | PINS | Sampled pin levels |
| pin_out | output | PINS | Pin drive values |
| pin_oe | output | PINS | Pin drive enables (1 = drive) |
| trig | output | 1 | Strobe output for external equipment |

## Verification
A wrong address or divider count shows on `pin_out`, `pin_oe` and `trig` in the very clock where the vector should have changed. The pins are compared every clock, so the error is seen within one clock of its cause. A wrong capture address or capture cycle stays hidden until the record is read. It then shows as a mismatching `rd_data` one clock after the affected address is presented. A write that slips in during a run only appears when that vector is replayed later, so the bench replays the protected vector after a run with such a write attempt.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  // which host-writable memory a write targets
  typedef enum logic {
    SEL_DRIVE = 1'b0,
    SEL_CTRL  = 1'b1
  } mem_sel_e;
endpackage

// File: rtl/vseq_ram.sv
module vseq_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vseq_addr_gen.sv
module vseq_addr_gen #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DIVW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic            loop_en,
  input  logic [AW-1:0]   start_addr,
  input  logic [AW-1:0]   end_addr,
  input  logic [DIVW-1:0] rate_div,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   addr,
  output logic            vec_last
);
  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  logic [DIVW-1:0] cnt, div_q;
  logic [AW-1:0]   first_q, last_q, addr_inc;
  logic            loop_q, stop_pend, finish;

  assign vec_last = busy && (cnt == div_q);
  assign addr_inc = (addr == TOP_ADDR) ? '0 : addr + AW'(1);
  assign finish   = stop_pend || stop || ((addr == last_q) && !loop_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      addr      <= '0;
      cnt       <= '0;
      div_q     <= '0;
      first_q   <= '0;
      last_q    <= '0;
      loop_q    <= 1'b0;
      stop_pend <= 1'b0;
    end else if (busy) begin
      if (vec_last) begin
        cnt <= '0;
        if (finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (addr == last_q) begin
          addr <= first_q;
        end else begin
          addr <= addr_inc;
        end
      end else begin
        cnt <= cnt + DIVW'(1);
        if (stop) stop_pend <= 1'b1;
      end
    end else if (start) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      addr      <= start_addr;
      cnt       <= '0;
      div_q     <= rate_div;
      first_q   <= start_addr;
      last_q    <= end_addr;
      loop_q    <= loop_en;
      stop_pend <= 1'b0;
    end
  end

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !vec_last) |=> $stable(addr));
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= div_q));
  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && addr == $past(start_addr)));
  // R8
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: rtl/vseq_engine.sv
module vseq_engine #(
  parameter int PINS  = 8,
  parameter int DEPTH = 16,
  parameter int DIVW  = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic            wr_sel,
  input  logic [AW-1:0]   wr_addr,
  input  logic [PINS:0]   wr_data,
  input  logic            start,
  input  logic            stop,
  input  logic            loop_en,
  input  logic [AW-1:0]   start_addr,
  input  logic [AW-1:0]   end_addr,
  input  logic [DIVW-1:0] rate_div,
  output logic            busy,
  output logic            done,
  input  logic [AW-1:0]   rd_addr,
  output logic [PINS-1:0] rd_data,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            trig
);
  import vseq_pkg::*;

  logic [AW-1:0]   addr;
  logic            vec_last, wr_fire;
  logic [PINS-1:0] drv_word, rec_word;
  logic [PINS:0]   ctl_word;

  assign wr_ready = !busy;
  assign wr_fire  = wr_valid && wr_ready;

  vseq_addr_gen #(.DEPTH(DEPTH), .AW(AW), .DIVW(DIVW)) u_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .loop_en(loop_en),
    .start_addr(start_addr), .end_addr(end_addr), .rate_div(rate_div),
    .busy(busy), .done(done), .addr(addr), .vec_last(vec_last)
  );

  vseq_ram #(.W(PINS), .DEPTH(DEPTH), .AW(AW)) u_drive_mem (
    .clk(clk), .we(wr_fire && (mem_sel_e'(wr_sel) == SEL_DRIVE)),
    .waddr(wr_addr), .wdata(wr_data[PINS-1:0]), .raddr(addr), .rdata(drv_word)
  );

  vseq_ram #(.W(PINS+1), .DEPTH(DEPTH), .AW(AW)) u_ctrl_mem (
    .clk(clk), .we(wr_fire && (mem_sel_e'(wr_sel) == SEL_CTRL)),
    .waddr(wr_addr), .wdata(wr_data), .raddr(addr), .rdata(ctl_word)
  );

  vseq_ram #(.W(PINS), .DEPTH(DEPTH), .AW(AW)) u_record_mem (
    .clk(clk), .we(vec_last), .waddr(addr), .wdata(pin_in),
    .raddr(rd_addr), .rdata(rec_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rec_word;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign pin_oe[i]  = busy & ctl_word[i];
    assign pin_out[i] = busy & drv_word[i];
  end
  assign trig = busy & ctl_word[PINS];

  // R6
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pin_oe == '0 && pin_out == '0 && !trig));
  // R3
  no_write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_valid) |-> !wr_fire);
endmodule

// File: tb/vseq_engine_test.sv
module vseq_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int PINS  = 8;
  localparam int DEPTH = 16;
  localparam int DIVW  = 4;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_sel = 0, start = 0, stop = 0, loop_en = 0;
  logic [AW-1:0] wr_addr = '0, start_addr = '0, end_addr = '0, rd_addr = '0;
  logic [PINS:0] wr_data = '0;
  logic [DIVW-1:0] rate_div = '0;
  logic wr_ready, busy, done, trig;
  logic [PINS-1:0] rd_data, pin_in, pin_out, pin_oe;
  logic [PINS-1:0] dev = 8'h3C;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // emulated device: enabled pins loop back, released pins carry device data
  assign pin_in = (pin_out & pin_oe) | (dev & ~pin_oe);

  vseq_engine #(.PINS(PINS), .DEPTH(DEPTH), .DIVW(DIVW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
    .stop(stop), .loop_en(loop_en), .start_addr(start_addr), .end_addr(end_addr),
    .rate_div(rate_div), .busy(busy), .done(done), .rd_addr(rd_addr),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .trig(trig)
  );

  // ---------------- behavioural reference model ----------------
  logic [PINS-1:0] m_drv [DEPTH];
  logic [PINS:0]   m_ctl [DEPTH];
  logic [PINS-1:0] m_rec [DEPTH];
  bit              m_recv [DEPTH];
  logic [PINS-1:0] m_rd;
  bit m_rd_ok = 0, m_busy = 0, m_done = 0, m_loop = 0, m_stopp = 0;
  int m_addr = 0, m_cnt = 0, m_div = 0, m_first = 0, m_last = 0;

  function automatic logic [PINS-1:0] exp_oe();
    return m_busy ? m_ctl[m_addr][PINS-1:0] : '0;
  endfunction
  function automatic logic [PINS-1:0] exp_out();
    return m_busy ? m_drv[m_addr] : '0;
  endfunction
  function automatic logic exp_trig();
    return m_busy ? m_ctl[m_addr][PINS] : 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rd_ok = 0; m_addr = 0; m_cnt = 0;
      for (int i = 0; i < DEPTH; i++) m_recv[i] = 0;
    end else begin
      m_rd_ok = m_recv[rd_addr];
      m_rd    = m_rec[rd_addr];
      if (wr_valid && !m_busy) begin
        if (wr_sel == 1'b0) m_drv[wr_addr] = wr_data[PINS-1:0];
        else                m_ctl[wr_addr] = wr_data;
      end
      if (m_busy) begin
        if (m_cnt == m_div) begin
          m_rec[m_addr]  = (exp_out() & exp_oe()) | (dev & ~exp_oe());
          m_recv[m_addr] = 1;
          m_cnt = 0;
          if (m_stopp || stop || (m_addr == m_last && !m_loop)) begin
            m_busy = 0; m_done = 1;
          end else if (m_addr == m_last) m_addr = m_first;
          else m_addr = (m_addr + 1) % DEPTH;
        end else begin
          m_cnt++;
          if (stop) m_stopp = 1;
        end
      end else if (start) begin
        m_busy = 1; m_done = 0; m_addr = int'(start_addr); m_cnt = 0;
        m_div = int'(rate_div); m_first = int'(start_addr);
        m_last = int'(end_addr); m_loop = loop_en; m_stopp = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6 pin_oe", 32'(pin_oe), 32'(exp_oe()));
      chk("R6 pin_out", 32'(pin_out), 32'(exp_out()));
      chk("R11 trig", 32'(trig), 32'(exp_trig()));
      chk("R4 busy", 32'(busy), 32'(m_busy));
      chk("R8 done", 32'(done), 32'(m_done));
      chk("R3 wr_ready", 32'(wr_ready), 32'(!m_busy));
      if (m_rd_ok) chk("R7 rd_data", 32'(rd_data), 32'(m_rd));
    end
    dev = dev * 8'd5 + 8'd1;
  end

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
    end
  end

  function automatic logic [PINS-1:0] drv_pat(input int i);
    return PINS'(i * 29) ^ 8'h5A;
  endfunction
  function automatic logic [PINS:0] ctl_pat(input int i);
    return {(i % 3 == 0), PINS'(8'hF0 ^ PINS'(i * 17))};
  endfunction

  task automatic host_wr(input logic sel, input int a, input logic [PINS:0] d);
    wr_valid = 1; wr_sel = sel; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic run(input int s, input int e, input int d, input bit lp, output int n);
    start_addr = AW'(s); end_addr = AW'(e); rate_div = DIVW'(d); loop_en = lp;
    start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (busy === 1'b1 && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic readback(input int a);
    rd_addr = AW'(a);
    @(negedge clk);
    chk("R7 readback", 32'(rd_data), 32'(m_rec[a]));
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 trig", 32'(trig), 0);
    chk("R1 rd_data", 32'(rd_data), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 wr_ready", 32'(wr_ready), 1);

    // R2 load both memories
    for (int i = 0; i < DEPTH; i++) begin
      host_wr(1'b0, i, {1'b0, drv_pat(i)});
      host_wr(1'b1, i, ctl_pat(i));
    end

    // R5 one vector per clock, R8 end of run
    run(2, 6, 0, 0, n);
    chk("R5 cycles div0", 32'(n), 5);
    chk("R8 done after run", 32'(done), 1);
    for (int a = 2; a <= 6; a++) readback(a);

    // R5 divider and address wrap through DEPTH-1 -> 0
    run(14, 1, 3, 0, n);
    chk("R5 cycles div3 wrap", 32'(n), 16);
    readback(15); readback(0); readback(1);

    // R9 looping, R3 blocked write, R4 start while busy, R10 stop
    start_addr = 4; end_addr = 5; rate_div = 1; loop_en = 1;
    start = 1; @(negedge clk); start = 0;
    repeat (9) @(negedge clk);
    chk("R3 wr_ready low in run", 32'(wr_ready), 0);
    host_wr(1'b0, 4, 9'h1FF);
    host_wr(1'b1, 4, 9'h000);
    start_addr = 9; start = 1; @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    chk("R9 still running", 32'(busy), 1);
    stop = 1; @(negedge clk); stop = 0;
    n = 0;
    while (busy === 1'b1 && n < 100) begin n++; @(negedge clk); end
    chk("R10 done after stop", 32'(done), 1);
    readback(4); readback(5);

    // R3 protected vector replays its original content
    start_addr = 4; end_addr = 4; rate_div = 2; loop_en = 0;
    start = 1; @(negedge clk); start = 0;
    chk("R3 drive kept", 32'(pin_out), 32'(drv_pat(4)));
    chk("R3 enable kept", 32'(pin_oe), 32'(ctl_pat(4) & 9'h0FF));
    repeat (4) @(negedge clk);

    // R10 stop during the first clock of a single long vector
    start_addr = 9; end_addr = 12; rate_div = 7; loop_en = 0;
    start = 1; @(negedge clk); start = 0;
    stop = 1; @(negedge clk); stop = 0;
    n = 1;
    while (busy === 1'b1 && n < 100) begin n++; @(negedge clk); end
    chk("R10 stop finishes vector", 32'(n), 8);
    readback(9);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule